// File: doc/BRIEF.md
# Byte-Wide SPI Master with Programmable Rate and Select Timing

This block is a single-byte SPI master running from a 48 MHz system clock. A 16-bit configuration word, written and read through a simple register port, sets the SCK idle level and sampling phase. It also selects one of sixteen SCK rates and sets a slave-select guard interval measured in half-bit times. A one-cycle start strobe with a transmit byte launches a transfer. The block shifts the byte out most significant bit first and samples the input line on the same frame. It then returns the captured byte alongside a one-cycle done strobe.

When the guard code is nonzero, the block frames each transfer automatically. Slave select falls, waits the guard interval, clocks the byte, waits the guard interval again, and rises. It then stays high for one more guard interval before a new transfer can start. A guard code of zero hands slave select to a manual input. A shared-line mode lets the data output be released for receive-only bytes. The master-enable bit is frozen while a transfer is in flight.

Top module: `spi_xfer_master`

## Requirements
- R1: After reset the configuration word reads 0x081F. That is: guard code [4:0]=31, rate [8:5]=0, idle-high bit [9]=0, early-phase bit [10]=0, shared-line bit [11]=1, master-enable [12]=0, select-drive [13]=0, busy [14]=0, bit 15 reads 0. Also after reset, ss_n is high and done is low.
- R2: The rate code sets the half-bit time H in system clocks. Codes 0 to 11 give H = 2,3,4,6,8,12,16,24,32,48,64,96. Codes 12 and 14 give 64, and codes 13 and 15 give 96. With guard code 0, done rises 16*H cycles after the clock edge that accepts start.
- R3: Data leaves on mosi most significant bit first. mosi already holds bit 7 at the first SCK edge. The byte sampled on miso at the SCK edges appears on rx_byte while done is high, so a mosi-to-miso loopback returns the transmitted byte.
- R4: While no transfer is in flight, sck rests at the inverse of bit [9]: bit 9 = 1 gives an idle-low SCK, and bit 9 = 0 gives an idle-high SCK.
- R5: With guard code N>0, the first SCK edge comes N*H cycles after the accepting edge when bit [10]=1. When bit [10]=0, it comes N*H+H cycles after that edge.
- R6: With guard code N>0, ss_n goes low in the cycle after start is accepted. done rises 2*N*H+16*H cycles after the accepting edge, and busy stays set for N*H further cycles with ss_n high.
- R7: With guard code 0, ss_n follows the ss_manual input directly.
- R8: ss_oe equals configuration bit [13].
- R9: Bit [14] reads 1 while a transfer, including its guard intervals, is in flight. A write made then leaves bit [12] unchanged. When idle, bit [12] is written normally.
- R10: A start is ignored when bit [12] is 0 or a transfer is already in flight.
- R11: With bit [11]=0, mosi_oe is always 1. With bit [11]=1, mosi_oe is 1 only during a transfer started with rx_only=0.
- R12: done is high for exactly one cycle per transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (48 MHz) |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 16 | Configuration write data |
| cfg_rdata | output | 16 | Configuration readback with busy bit |
| start | input | 1 | One-cycle transfer request |
| tx_byte | input | 8 | Byte to send |
| rx_only | input | 1 | Release the data line for this byte in shared-line mode |
| rx_byte | output | 8 | Received byte, valid with done |
| done | output | 1 | One-cycle completion strobe |
| ss_manual | input | 1 | Slave-select level used when guard code is 0 |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| mosi_oe | output | 1 | Output enable for the data line |
| miso | input | 1 | Serial data in |
| ss_n | output | 1 | Active-low slave select |
| ss_oe | output | 1 | Output enable for slave select |

## Verification
A wrong half-bit count or rate lookup changes the cycle at which done rises by at least H cycles per half-bit. It is therefore caught the first time a transfer finishes. A corrupted guard counter moves the first SCK edge, the done strobe or the busy drop, and each of these is timed to the exact cycle. An off-by-one in the shift or sample order shows as a wrong looped-back byte at done. A wrong select or output-enable state shows on ss_n or mosi_oe mid-transfer.

// File: rtl/spi_xfer_master.sv
module spi_xfer_master #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [15:0]       cfg_wdata,
  output logic [15:0]       cfg_rdata,
  input  logic              start,
  input  logic [DATA_W-1:0] tx_byte,
  input  logic              rx_only,
  output logic [DATA_W-1:0] rx_byte,
  output logic              done,
  input  logic              ss_manual,
  output logic              sck,
  output logic              mosi,
  output logic              mosi_oe,
  input  logic              miso,
  output logic              ss_n,
  output logic              ss_oe
);
  localparam int HALVES = 2 * DATA_W;
  localparam int K_W    = $clog2(HALVES);
  localparam int HC_W   = 7;
  localparam logic [K_W-1:0] K_LAST = K_W'(HALVES - 1);

  typedef enum logic [2:0] {S_IDLE, S_LEAD, S_SHIFT, S_TRAIL, S_GAP} st_t;

  st_t st;
  logic [4:0]        gap_q, nlat, dcnt;
  logic [3:0]        rate_q;
  logic              pol_q, pha_q, hdx_q, men_q, ssen_q, rxo;
  logic [HC_W-1:0]   hcnt, hlim;
  logic [K_W-1:0]    k;
  logic [DATA_W-1:0] txsh, rxsh;

  function automatic logic [HC_W-1:0] half_of(input logic [3:0] c);
    case (c)
      4'd0:  half_of = 7'd2;
      4'd1:  half_of = 7'd3;
      4'd2:  half_of = 7'd4;
      4'd3:  half_of = 7'd6;
      4'd4:  half_of = 7'd8;
      4'd5:  half_of = 7'd12;
      4'd6:  half_of = 7'd16;
      4'd7:  half_of = 7'd24;
      4'd8:  half_of = 7'd32;
      4'd9:  half_of = 7'd48;
      4'd11, 4'd13, 4'd15: half_of = 7'd96;
      default: half_of = 7'd64;
    endcase
  endfunction

  wire busy   = (st != S_IDLE);
  wire tick   = (hcnt == '0);
  wire frame  = (st == S_LEAD) || (st == S_SHIFT) || (st == S_TRAIL);
  wire manual = busy ? (nlat == 5'd0) : (gap_q == 5'd0);
  wire active = (st == S_SHIFT) && (k[0] ^ pha_q);

  assign cfg_rdata = {1'b0, busy, ssen_q, men_q, hdx_q, pha_q, pol_q, rate_q, gap_q};
  assign sck       = pol_q ? active : ~active;
  assign mosi      = txsh[DATA_W-1];
  assign mosi_oe   = ~hdx_q | (busy & ~rxo);
  assign ss_n      = manual ? ss_manual : ~frame;
  assign ss_oe     = ssen_q;
  assign rx_byte   = rxsh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_q  <= 5'd31;
      rate_q <= '0;
      pol_q  <= 1'b0;
      pha_q  <= 1'b0;
      hdx_q  <= 1'b1;
      men_q  <= 1'b0;
      ssen_q <= 1'b0;
    end else if (cfg_we) begin
      gap_q  <= cfg_wdata[4:0];
      rate_q <= cfg_wdata[8:5];
      pol_q  <= cfg_wdata[9];
      pha_q  <= cfg_wdata[10];
      hdx_q  <= cfg_wdata[11];
      ssen_q <= cfg_wdata[13];
      if (!busy) men_q <= cfg_wdata[12];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= S_IDLE;
      hcnt <= '0;
      hlim <= '0;
      nlat <= '0;
      dcnt <= '0;
      k    <= '0;
      txsh <= '0;
      rxsh <= '0;
      rxo  <= 1'b0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (busy) hcnt <= tick ? hlim : hcnt - 1'b1;
      case (st)
        S_IDLE: if (start && men_q) begin
          hlim <= half_of(rate_q) - 1'b1;
          hcnt <= half_of(rate_q) - 1'b1;
          nlat <= gap_q;
          dcnt <= gap_q - 1'b1;
          k    <= '0;
          txsh <= tx_byte;
          rxo  <= rx_only;
          st   <= (gap_q == 5'd0) ? S_SHIFT : S_LEAD;
        end
        S_LEAD: if (tick) begin
          if (dcnt == 5'd0) begin
            st <= S_SHIFT;
            k  <= '0;
          end else dcnt <= dcnt - 1'b1;
        end
        S_SHIFT: if (tick) begin
          if (!k[0]) rxsh <= {rxsh[DATA_W-2:0], miso};
          else if (k != K_LAST) txsh <= txsh << 1;
          k <= k + 1'b1;
          if (k == K_LAST) begin
            if (nlat == 5'd0) begin
              done <= 1'b1;
              st   <= S_IDLE;
            end else begin
              st   <= S_TRAIL;
              dcnt <= nlat - 1'b1;
            end
          end
        end
        S_TRAIL: if (tick) begin
          if (dcnt == 5'd0) begin
            done <= 1'b1;
            st   <= S_GAP;
            dcnt <= nlat - 1'b1;
          end else dcnt <= dcnt - 1'b1;
        end
        S_GAP: if (tick) begin
          if (dcnt == 5'd0) st <= S_IDLE;
          else dcnt <= dcnt - 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

module spi_xfer_master_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        start,
  input logic        cfg_we,
  input logic [15:0] cfg_rdata,
  input logic        done,
  input logic        sck,
  input logic        ss_n,
  input logic        mosi_oe,
  input logic [4:0]  nlat
);
  // R9
  mode_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rdata[14] && cfg_we) |=> (cfg_rdata[12] == $past(cfg_rdata[12])));
  // R12
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R11
  duplex_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_rdata[11] |-> mosi_oe);
  // R10
  idle_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_rdata[14] && start && !cfg_rdata[12]) |=> !cfg_rdata[14]);
  // R4
  idle_sck_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_rdata[14] |-> (sck == !cfg_rdata[9]));
  // R6
  frame_ss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rdata[14] && nlat != 5'd0 && sck != !cfg_rdata[9]) |-> !ss_n);
endmodule

bind spi_xfer_master spi_xfer_master_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .cfg_we(cfg_we),
  .cfg_rdata(cfg_rdata), .done(done), .sck(sck), .ss_n(ss_n),
  .mosi_oe(mosi_oe), .nlat(nlat)
);

// File: tb/tb_spi_xfer_master.sv
module tb_spi_xfer_master;
  localparam int CLK_P = 20;

  logic clk = 0, rst_n = 0, cfg_we = 0, start = 0, rx_only = 0, ss_manual = 1;
  logic [15:0] cfg_wdata = '0;
  logic [15:0] cfg_rdata;
  logic [7:0]  tx_byte = '0, rx_byte;
  logic done, sck, mosi, mosi_oe, ss_n, ss_oe;
  logic lb = 1, miso_drv = 0;
  wire  miso = lb ? mosi : miso_drv;

  int n_chk = 0, n_fail = 0;
  int r_done, r_first, r_busy, r_dhigh;
  logic [7:0] r_rx;
  logic r_mosi1, r_ss0;

  always #(CLK_P/2) clk = ~clk;

  spi_xfer_master dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .start(start), .tx_byte(tx_byte), .rx_only(rx_only),
    .rx_byte(rx_byte), .done(done), .ss_manual(ss_manual), .sck(sck),
    .mosi(mosi), .mosi_oe(mosi_oe), .miso(miso), .ss_n(ss_n), .ss_oe(ss_oe)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int exp_half(input int c);
    int t[16] = '{2,3,4,6,8,12,16,24,32,48,64,96,64,96,64,96};
    return t[c];
  endfunction

  function automatic logic [15:0] mk(input bit ssen, input bit men, input bit hdx,
      input bit pha, input bit pol, input int rate, input int gap);
    return {2'b00, ssen, men, hdx, pha, pol, rate[3:0], gap[4:0]};
  endfunction

  task automatic wr(input logic [15:0] w);
    @(negedge clk); cfg_we = 1; cfg_wdata = w;
    @(negedge clk); cfg_we = 0;
  endtask

  task automatic run_xfer(input logic [7:0] tx, input logic rxo);
    logic prev;
    r_done = -1; r_first = -1; r_busy = -1; r_dhigh = 0;
    @(negedge clk); tx_byte = tx; rx_only = rxo; start = 1; prev = sck;
    @(posedge clk); #1 start = 0;
    for (int n = 0; n < 6000; n++) begin
      @(negedge clk);
      if (n == 0) r_ss0 = ss_n;
      if (r_first < 0 && sck !== prev) begin r_first = n; r_mosi1 = mosi; end
      if (done) begin
        r_dhigh++;
        if (r_done < 0) begin r_done = n; r_rx = rx_byte; end
      end
      if (!cfg_rdata[14]) begin r_busy = n; break; end
    end
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk(cfg_rdata == 16'h081F, "R1 cfg", cfg_rdata, 16'h081F);
    chk(ss_n == 1'b1, "R1 ss_n", ss_n, 1);
    chk(done == 1'b0, "R1 done", done, 0);
    chk(sck == 1'b1, "R4 idle sck pol0", sck, 1);
  endtask

  task automatic t_rates;
    int codes[9] = '{0, 1, 3, 7, 11, 12, 13, 14, 15};
    lb = 1;
    foreach (codes[i]) begin
      wr(mk(1, 1, 0, 0, 1, codes[i], 0));
      run_xfer(8'h5A ^ 8'(i), 0);
      chk(r_done == 16 * exp_half(codes[i]), "R2 rate timing", r_done, 16 * exp_half(codes[i]));
      chk(r_rx == (8'h5A ^ 8'(i)), "R3 loopback", r_rx, 8'h5A ^ 8'(i));
      chk(r_dhigh == 1, "R12 done width", r_dhigh, 1);
    end
  endtask

  task automatic t_auto;
    lb = 1;
    wr(mk(1, 1, 0, 0, 1, 0, 3));
    run_xfer(8'hC3, 0);
    chk(r_ss0 == 1'b0, "R6 ss low after accept", r_ss0, 0);
    chk(r_first == 8, "R5 first edge pha0", r_first, 8);
    chk(r_done == 44, "R6 done time", r_done, 44);
    chk(r_busy == 50, "R6 busy end", r_busy, 50);
    chk(r_dhigh == 1, "R12 done width auto", r_dhigh, 1);
    chk(ss_n == 1'b1, "R6 ss high after", ss_n, 1);
    chk(r_rx == 8'hC3, "R3 loopback auto", r_rx, 8'hC3);
    wr(mk(1, 1, 0, 1, 1, 0, 3));
    run_xfer(8'h3C, 0);
    chk(r_first == 6, "R5 first edge pha1", r_first, 6);
    chk(r_rx == 8'h3C, "R3 loopback pha1", r_rx, 8'h3C);
  endtask

  task automatic t_pattern;
    wr(mk(1, 1, 0, 0, 1, 1, 1));
    lb = 1;
    run_xfer(8'h81, 0);
    chk(r_rx == 8'h81, "R3 loopback 81", r_rx, 8'h81);
    chk(r_mosi1 == 1'b1, "R3 msb first", r_mosi1, 1);
    run_xfer(8'h7E, 0);
    chk(r_mosi1 == 1'b0, "R3 msb first 7E", r_mosi1, 0);
    lb = 0; miso_drv = 1;
    run_xfer(8'h00, 0);
    chk(r_rx == 8'hFF, "R3 miso ones", r_rx, 8'hFF);
    lb = 1;
  endtask

  task automatic t_pol;
    wr(mk(1, 1, 0, 0, 1, 0, 0));
    @(negedge clk); chk(sck == 1'b0, "R4 idle pol1", sck, 0);
    wr(mk(1, 1, 0, 0, 0, 0, 0));
    @(negedge clk); chk(sck == 1'b1, "R4 idle pol0", sck, 1);
  endtask

  task automatic t_manual;
    wr(mk(1, 1, 0, 0, 0, 0, 0));
    ss_manual = 0; @(negedge clk);
    chk(ss_n == 1'b0, "R7 manual low", ss_n, 0);
    ss_manual = 1; @(negedge clk);
    chk(ss_n == 1'b1, "R7 manual high", ss_n, 1);
  endtask

  task automatic t_ssoe;
    wr(mk(0, 1, 0, 0, 0, 0, 0));
    chk(ss_oe == 1'b0, "R8 ss_oe off", ss_oe, 0);
    wr(mk(1, 1, 0, 0, 0, 0, 0));
    chk(ss_oe == 1'b1, "R8 ss_oe on", ss_oe, 1);
  endtask

  task automatic t_lock;
    int dn;
    wr(mk(1, 1, 0, 0, 1, 3, 2));
    @(negedge clk); tx_byte = 8'hA5; start = 1;
    @(negedge clk); start = 0;
    chk(cfg_rdata[14] == 1'b1, "R9 busy set", cfg_rdata[14], 1);
    cfg_we = 1; cfg_wdata = mk(1, 0, 0, 0, 1, 3, 2);
    @(negedge clk); cfg_we = 0;
    chk(cfg_rdata[12] == 1'b1, "R9 master-enable held", cfg_rdata[12], 1);
    dn = 0;
    for (int i = 0; i < 400; i++) begin
      if (i == 5) start = 1;
      if (i == 6) start = 0;
      if (done) dn++;
      if (!cfg_rdata[14]) break;
      @(negedge clk);
    end
    chk(dn == 1, "R10 start while busy ignored", dn, 1);
    wr(mk(1, 0, 0, 0, 1, 3, 2));
    chk(cfg_rdata[12] == 1'b0, "R9 idle write", cfg_rdata[12], 0);
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
    chk(cfg_rdata[14] == 1'b0, "R10 disabled start", cfg_rdata[14], 0);
  endtask

  task automatic t_hdx;
    wr(mk(1, 1, 0, 0, 1, 0, 0));
    chk(mosi_oe == 1'b1, "R11 full duplex idle", mosi_oe, 1);
    wr(mk(1, 1, 1, 0, 1, 0, 0));
    chk(mosi_oe == 1'b0, "R11 shared idle", mosi_oe, 0);
    @(negedge clk); rx_only = 1; start = 1;
    @(negedge clk); start = 0; @(negedge clk);
    chk(mosi_oe == 1'b0, "R11 rx-only released", mosi_oe, 0);
    repeat (40) @(negedge clk);
    rx_only = 0; start = 1;
    @(negedge clk); start = 0; @(negedge clk);
    chk(mosi_oe == 1'b1, "R11 tx driven", mosi_oe, 1);
    repeat (40) @(negedge clk);
  endtask

  bit finished = 0;

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_pol();
    t_ssoe();
    t_manual();
    t_rates();
    t_auto();
    t_pattern();
    t_lock();
    t_hdx();
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule